// File: doc/BRIEF.md
# RTC Alarm Match and Interrupt Controller

This block watches the calendar time of a real-time clock and raises an alarm when the time reaches a programmed moment. It compares five BCD fields of the current time against five alarm fields: month, day of month, hour, minute and second. A 5-bit repeat code chooses how many of those fields take part, so the alarm can fire once a year, once a month, once a day, once an hour, once a minute or once a second. The comparison happens only in the cycle that carries the once-per-second tick, so each qualifying second gives exactly one alarm event.

Every event sets a sticky alarm flag. An active-low interrupt is also driven if the alarm enable is set. In battery back-up mode the interrupt additionally needs the battery alarm enable. A flag-register read strobe clears both the flag and the interrupt. While the bus pointer rests on the flag register address, a new event sets the flag, but the interrupt is held pending and is released once the pointer moves away. The block owns the two enable bits and clears them at reset, so an alarm that occurs during power-up only sets the flag.

Top module: `rtc_alarm_ctrl`

## Requirements
- R1: With repeat code 5'b00000 an event needs month, date, hour, minute and second all equal to the alarm fields; a difference in any one of them, including month, gives no event.
- R2: Repeat code 5'b10000 compares date, hour, minute and second, ignoring month. Repeat code 5'b11000 compares hour, minute and second, ignoring date and month.
- R3: Repeat code 5'b11100 compares minute and second. Repeat code 5'b11110 compares second only. Repeat code 5'b11111 gives an event on every tick.
- R4: Any repeat code other than the six defined codes behaves as 5'b11111 (an event on every tick).
- R5: An event is evaluated only in a cycle where sec_tick is high. Without a tick, matching fields set nothing.
- R6: An event sets alarm_flag in the clock edge that samples the tick. irq_n falls in that same edge only when the alarm enable (en_data[0]) is set. With the enable clear, the flag sets and irq_n stays high.
- R7: A flag_rd strobe with no coincident event clears alarm_flag and returns irq_n high at the next edge.
- R8: While bus_ptr equals FLAG_ADDR (default 6'h0F), an event sets alarm_flag but leaves irq_n high. The first edge after bus_ptr moves elsewhere drives irq_n low, unless a flag_rd strobe has cleared the pending event first.
- R9: While on_battery is high, an event drives irq_n low only if both the battery enable (en_data[1]) and the alarm enable (en_data[0]) are set.
- R10: Reset clears alarm_flag and both enables and sets irq_n high. An en_wr strobe loads en_data[1:0] into {battery enable, alarm enable}.
- R11: Repeat code 5'b00000 together with an alarm date of 8'h00 disables the alarm: no event even when every field matches.
- R12: If a flag_rd strobe and an event fall in the same cycle, the event wins and alarm_flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| sec_tick | input | 1 | One-cycle pulse once per second |
| now_sec | input | 8 | Current second, BCD |
| now_min | input | 8 | Current minute, BCD |
| now_hour | input | 8 | Current hour, BCD |
| now_date | input | 8 | Current day of month, BCD |
| now_month | input | 8 | Current month, BCD |
| alm_sec | input | 8 | Alarm second, BCD |
| alm_min | input | 8 | Alarm minute, BCD |
| alm_hour | input | 8 | Alarm hour, BCD |
| alm_date | input | 8 | Alarm day of month, BCD |
| alm_month | input | 8 | Alarm month, BCD |
| rpt_code | input | 5 | Repeat code |
| bus_ptr | input | 6 | Current bus register pointer |
| flag_rd | input | 1 | Strobe: flag register is being read |
| on_battery | input | 1 | High in battery back-up mode |
| en_wr | input | 1 | Strobe: load the enable bits |
| en_data | input | 2 | {battery enable, alarm enable} |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions assume that sec_tick is a single-cycle pulse and that the time, alarm fields and repeat code are stable in the tick cycle. They also assume that bus_ptr, flag_rd and on_battery change only between clock edges. The bench meets these assumptions by changing every input at the falling clock edge, holding each tick for exactly one cycle and setting fields only while the tick is low. Outputs are sampled one falling edge after the rising edge that acts on them.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int NUM_FIELDS = 5;   // index 0 sec, 1 min, 2 hour, 3 date, 4 month
  localparam int FIELD_W    = 8;
  localparam int RPT_W      = 5;
  localparam int DATE_IDX   = 3;

  typedef enum logic [2:0] {
    MODE_SEC, MODE_MIN, MODE_HOUR, MODE_DAY, MODE_MONTH, MODE_YEAR
  } rpt_mode_e;

  // Map the repeat code onto a mode; unknown codes fall back to per-second.
  function automatic rpt_mode_e decode_rpt(logic [RPT_W-1:0] code);
    case (code)
      5'b00000: return MODE_YEAR;
      5'b10000: return MODE_MONTH;
      5'b11000: return MODE_DAY;
      5'b11100: return MODE_HOUR;
      5'b11110: return MODE_MIN;
      default:  return MODE_SEC;
    endcase
  endfunction

  // Fields that take part in the compare, one bit per field index.
  function automatic logic [NUM_FIELDS-1:0] mode_mask(rpt_mode_e m);
    case (m)
      MODE_YEAR:  return 5'b11111;
      MODE_MONTH: return 5'b01111;
      MODE_DAY:   return 5'b00111;
      MODE_HOUR:  return 5'b00011;
      MODE_MIN:   return 5'b00001;
      default:    return 5'b00000;
    endcase
  endfunction
endpackage

// File: rtl/alarm_mode_decode.sv
module alarm_mode_decode
  import rtc_alarm_pkg::*;
(
  input  logic [RPT_W-1:0]      rpt_code,
  input  logic [FIELD_W-1:0]    alm_date,
  output logic [NUM_FIELDS-1:0] field_mask,
  output logic                  alarm_off
);
  rpt_mode_e mode;

  always_comb begin
    mode       = decode_rpt(rpt_code);
    field_mask = mode_mask(mode);
    alarm_off  = (rpt_code == '0) && (alm_date == '0);
  end

  // R4: every mask is a contiguous run starting at the seconds field
  always_comb begin
    p_mask_thermo_r4 : assert ((field_mask & (field_mask + 5'd1)) == '0);
  end
endmodule

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp
  import rtc_alarm_pkg::*;
#(
  parameter int NF = NUM_FIELDS,
  parameter int FW = FIELD_W
) (
  input  logic [NF*FW-1:0] now_flat,
  input  logic [NF*FW-1:0] alm_flat,
  input  logic [NF-1:0]    field_mask,
  input  logic             sec_tick,
  input  logic             alarm_off,
  output logic             hit
);
  logic [NF-1:0] field_ok;

  for (genvar i = 0; i < NF; i++) begin : g_field
    assign field_ok[i] = !field_mask[i] ||
                         (now_flat[i*FW +: FW] == alm_flat[i*FW +: FW]);
  end

  assign hit = sec_tick && !alarm_off && (&field_ok);
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl #(
  parameter int              AW        = 6,
  parameter logic [AW-1:0]   FLAG_ADDR = 6'h0F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic          sec_tick,
  input  logic          flag_rd,
  input  logic [AW-1:0] bus_ptr,
  input  logic          on_battery,
  input  logic          en_wr,
  input  logic [1:0]    en_data,
  output logic          alarm_flag,
  output logic          irq_n
);
  logic afe_q, abe_q, af_q, irq_q, pend_q;
  logic parked, allow, fire_now;

  assign parked   = (bus_ptr == FLAG_ADDR);
  assign allow    = on_battery ? (afe_q && abe_q) : afe_q;
  assign fire_now = hit && allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      afe_q <= 1'b0;
      abe_q <= 1'b0;
    end else if (en_wr) begin
      afe_q <= en_data[0];
      abe_q <= en_data[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       af_q <= 1'b0;
    else if (hit)     af_q <= 1'b1;
    else if (flag_rd) af_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (fire_now) begin
      if (parked) pend_q <= 1'b1;
      else begin
        irq_q  <= 1'b1;
        pend_q <= 1'b0;
      end
    end else if (flag_rd) begin
      irq_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (pend_q && !parked) begin
      irq_q  <= 1'b1;
      pend_q <= 1'b0;
    end
  end

  assign alarm_flag = af_q;
  assign irq_n      = !irq_q;

  // R6: an active interrupt always has the flag behind it
  p_irq_has_flag_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> alarm_flag);
  // R5: the flag only rises after a tick cycle
  p_flag_on_tick_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(sec_tick));
  // R8: the interrupt never rises while the pointer was parked on the flag
  p_no_irq_parked_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(!irq_n) |-> ($past(bus_ptr) != FLAG_ADDR));
  // R7: a flag read without an event clears both outputs
  p_read_clears_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !hit) |=> (irq_n && !alarm_flag));
  // R9: a fresh battery-mode interrupt needs both enables
  p_batt_gate_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(!irq_n) && $past(on_battery) && !$past(pend_q)) |-> $past(afe_q && abe_q));
endmodule

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
  import rtc_alarm_pkg::*;
#(
  parameter int            AW        = 6,
  parameter logic [AW-1:0] FLAG_ADDR = 6'h0F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_tick,
  input  logic [FIELD_W-1:0] now_sec,
  input  logic [FIELD_W-1:0] now_min,
  input  logic [FIELD_W-1:0] now_hour,
  input  logic [FIELD_W-1:0] now_date,
  input  logic [FIELD_W-1:0] now_month,
  input  logic [FIELD_W-1:0] alm_sec,
  input  logic [FIELD_W-1:0] alm_min,
  input  logic [FIELD_W-1:0] alm_hour,
  input  logic [FIELD_W-1:0] alm_date,
  input  logic [FIELD_W-1:0] alm_month,
  input  logic [RPT_W-1:0]   rpt_code,
  input  logic [AW-1:0]      bus_ptr,
  input  logic               flag_rd,
  input  logic               on_battery,
  input  logic               en_wr,
  input  logic [1:0]         en_data,
  output logic               alarm_flag,
  output logic               irq_n
);
  localparam int FLAT_W = NUM_FIELDS * FIELD_W;

  logic [FLAT_W-1:0]     now_flat, alm_flat;
  logic [NUM_FIELDS-1:0] field_mask;
  logic                  alarm_off;
  logic                  hit;

  assign now_flat = {now_month, now_date, now_hour, now_min, now_sec};
  assign alm_flat = {alm_month, alm_date, alm_hour, alm_min, alm_sec};

  alarm_mode_decode u_decode (
    .rpt_code   (rpt_code),
    .alm_date   (alm_date),
    .field_mask (field_mask),
    .alarm_off  (alarm_off)
  );

  alarm_field_cmp #(.NF(NUM_FIELDS), .FW(FIELD_W)) u_cmp (
    .now_flat   (now_flat),
    .alm_flat   (alm_flat),
    .field_mask (field_mask),
    .sec_tick   (sec_tick),
    .alarm_off  (alarm_off),
    .hit        (hit)
  );

  alarm_irq_ctrl #(.AW(AW), .FLAG_ADDR(FLAG_ADDR)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit        (hit),
    .sec_tick   (sec_tick),
    .flag_rd    (flag_rd),
    .bus_ptr    (bus_ptr),
    .on_battery (on_battery),
    .en_wr      (en_wr),
    .en_data    (en_data),
    .alarm_flag (alarm_flag),
    .irq_n      (irq_n)
  );

  // R11: a disabled alarm never produces an event
  p_disabled_r11 : assert property (@(posedge clk) disable iff (!rst_n)
    ((rpt_code == '0) && (alm_date == '0)) |=> $stable(alarm_flag) || !alarm_flag);
endmodule

// File: tb/rtc_alarm_ctrl_bench.sv
module rtc_alarm_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic [7:0] now_sec, now_min, now_hour, now_date, now_month;
  logic [7:0] alm_sec, alm_min, alm_hour, alm_date, alm_month;
  logic [4:0] rpt_code = 5'b00000;
  logic [5:0] bus_ptr = 6'h00;
  logic       flag_rd = 1'b0;
  logic       on_battery = 1'b0;
  logic       en_wr = 1'b0;
  logic [1:0] en_data = 2'b00;
  logic       alarm_flag, irq_n;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  rtc_alarm_ctrl u_rtc_alarm_ctrl (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_date(now_date), .now_month(now_month),
    .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
    .alm_date(alm_date), .alm_month(alm_month),
    .rpt_code(rpt_code), .bus_ptr(bus_ptr), .flag_rd(flag_rd),
    .on_battery(on_battery), .en_wr(en_wr), .en_data(en_data),
    .alarm_flag(alarm_flag), .irq_n(irq_n)
  );

  // exp/act packed as {alarm_flag, irq_n}
  task automatic chk(string req, logic [1:0] exp);
    logic [1:0] act;
    act = {alarm_flag, irq_n};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s flag/irq_n actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic set_time_equal();
    now_sec = 8'h58; now_min = 8'h59; now_hour = 8'h23;
    now_date = 8'h31; now_month = 8'h12;
    alm_sec = 8'h58; alm_min = 8'h59; alm_hour = 8'h23;
    alm_date = 8'h31; alm_month = 8'h12;
  endtask

  task automatic tick();
    @(negedge clk) sec_tick = 1'b1;
    @(negedge clk) sec_tick = 1'b0;
  endtask

  task automatic read_flag();
    @(negedge clk) flag_rd = 1'b1;
    @(negedge clk) flag_rd = 1'b0;
  endtask

  task automatic set_en(logic abe, logic afe);
    @(negedge clk) begin en_wr = 1'b1; en_data = {abe, afe}; end
    @(negedge clk) en_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 reset state", 2'b01);
    set_time_equal();
    rpt_code = 5'b00000;
    tick();
    chk("R10 enables cleared by reset", 2'b11);
    read_flag();
    chk("R7 flag read clears", 2'b01);
  endtask

  task automatic t_year();
    set_en(1'b0, 1'b1);
    set_time_equal(); rpt_code = 5'b00000;
    tick();
    chk("R1 year match", 2'b10);
    read_flag();
    chk("R7 read clears irq and flag", 2'b01);
    now_month = 8'h11;
    tick();
    chk("R1 month differs no event", 2'b01);
  endtask

  task automatic t_month_day();
    set_time_equal(); now_month = 8'h03; rpt_code = 5'b10000;
    tick();
    chk("R2 month mode ignores month", 2'b10);
    read_flag();
    now_date = 8'h07; rpt_code = 5'b11000;
    tick();
    chk("R2 day mode ignores date", 2'b10);
    read_flag();
    now_hour = 8'h05;
    tick();
    chk("R2 day mode hour differs", 2'b01);
  endtask

  task automatic t_short_modes();
    set_time_equal(); now_hour = 8'h01; rpt_code = 5'b11100;
    tick();
    chk("R3 hour mode", 2'b10);
    read_flag();
    now_min = 8'h02; rpt_code = 5'b11110;
    tick();
    chk("R3 minute mode", 2'b10);
    read_flag();
    now_sec = 8'h03;
    tick();
    chk("R3 minute mode second differs", 2'b01);
    rpt_code = 5'b11111;
    tick();
    chk("R3 second mode", 2'b10);
    read_flag();
  endtask

  task automatic t_undefined();
    set_time_equal();
    now_sec = 8'h11; now_min = 8'h22; now_hour = 8'h03;
    now_date = 8'h04; now_month = 8'h05;
    rpt_code = 5'b01010;
    tick();
    chk("R4 undefined code acts per second", 2'b10);
    read_flag();
    rpt_code = 5'b00001;
    tick();
    chk("R4 undefined code 00001", 2'b10);
    read_flag();
  endtask

  task automatic t_no_tick();
    set_time_equal(); rpt_code = 5'b00000;
    repeat (3) @(negedge clk);
    chk("R5 no tick no event", 2'b01);
  endtask

  task automatic t_afe_off();
    set_en(1'b0, 1'b0);
    set_time_equal(); rpt_code = 5'b00000;
    tick();
    chk("R6 enable clear flag only", 2'b11);
    read_flag();
    set_en(1'b0, 1'b1);
  endtask

  task automatic t_parked();
    set_time_equal(); rpt_code = 5'b00000;
    bus_ptr = 6'h0F;
    tick();
    chk("R8 parked holds irq", 2'b11);
    @(negedge clk);
    chk("R8 still parked", 2'b11);
    bus_ptr = 6'h10;
    @(negedge clk);
    chk("R8 released after pointer moves", 2'b10);
    read_flag();
    bus_ptr = 6'h0F;
    tick();
    read_flag();
    bus_ptr = 6'h02;
    @(negedge clk);
    chk("R8 read cancels pending", 2'b01);
    bus_ptr = 6'h00;
  endtask

  task automatic t_battery();
    on_battery = 1'b1;
    set_time_equal(); rpt_code = 5'b00000;
    tick();
    chk("R9 battery needs both enables", 2'b11);
    read_flag();
    set_en(1'b1, 1'b1);
    tick();
    chk("R9 battery with both enables", 2'b10);
    read_flag();
    on_battery = 1'b0;
    set_en(1'b0, 1'b1);
  endtask

  task automatic t_disabled();
    set_time_equal();
    now_date = 8'h00; alm_date = 8'h00; rpt_code = 5'b00000;
    tick();
    chk("R11 disabled alarm", 2'b01);
  endtask

  task automatic t_collide();
    set_time_equal(); rpt_code = 5'b00000;
    @(negedge clk) begin sec_tick = 1'b1; flag_rd = 1'b1; end
    @(negedge clk) begin sec_tick = 1'b0; flag_rd = 1'b0; end
    chk("R12 event beats read", 2'b10);
    read_flag();
  endtask

  initial begin
    set_time_equal();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_year();
    t_month_day();
    t_short_modes();
    t_undefined();
    t_no_tick();
    t_afe_off();
    t_parked();
    t_battery();
    t_disabled();
    t_collide();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule